// File: doc/BRIEF.md
# Dual Alarm Comparator with Power-Enable Control

This block keeps two six-field BCD alarm settings (seconds, minutes, hours, day, month, year) and compares each one with a live calendar time delivered by a separate counter. It runs the comparison only on the cycle where the counter signals that the seconds value has changed. A full match on either alarm sets a sticky status flag. Software clears the flag by writing a one to it. Each flag can raise the shared alarm interrupt when its enable bit is set. The first alarm can also drive a wake output.

The second alarm controls system power. A power-sequencing state machine has two states, PWR_RUN and PWR_DOWN. In PWR_RUN the power-enable output is high. In PWR_DOWN it is low. When the power function is enabled, a second-alarm match takes the shutdown transition from PWR_RUN to PWR_DOWN. Software normally arms the second alarm about two seconds ahead of the current time just before shutting down. Four external wakeup pins pass through a two-stage synchronizer. Each pin has its own enable bit and polarity bit. In PWR_DOWN, any enabled pin at its active level takes the wakeup transition back to PWR_RUN. The block does not count calendar time itself.

Top module: `dual_alarm_pwr`

## Requirements
- R1: After reset all alarm fields, enables and flags are zero, `alarm_irq` and `wake_out` are low, and the state machine is in PWR_RUN, so `pwr_en_out` is high.
- R2: First-alarm field f (0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year) is an 8-bit register at byte offset 0x20+4*f. The second alarm's fields are at 0x80+4*f. Each reads back the value last written, in bits 7:0.
- R3: An alarm's flag (status register 0x44, bit 6 first alarm, bit 7 second alarm) sets on the clock edge where `tm_tick` is high and all six live fields equal that alarm's fields. It does not set when `tm_tick` is low or when any single field differs.
- R4: Writing 0x44 with a one in a flag's bit clears that flag, and a zero leaves it unchanged. When a match and a clear of the same flag fall in the same cycle, the flag stays set.
- R5: The interrupt-enable register 0x48 has bit 3 for the first alarm and bit 4 for the second. `alarm_irq` is high exactly while some flag and its enable bit are both set, starting in the cycle after the matching edge.
- R6: Bit 1 of the wake-enable register 0x7C, when set, makes `wake_out` follow the first alarm's flag. When it is clear, that flag does not drive `wake_out`.
- R7: Power register 0x98 has bit 16 as the power-function enable, bits 3:0 as the enables for pins 0 to 3, and bits 7:4 as the pin polarities, where a set bit means the pin is active low. All of these bits read back.
- R8: In PWR_RUN, a second-alarm match with bit 16 set takes the shutdown transition to PWR_DOWN, and `pwr_en_out` is low in the next cycle. With bit 16 clear, a match leaves the state in PWR_RUN.
- R9: In PWR_DOWN, an enabled pin held at its active level takes the wakeup transition to PWR_RUN within three clock edges of the change. This covers both active-high and active-low polarity. Pins that are disabled, or at their inactive level, leave the state in PWR_DOWN.
- R10: `wake_out` is also high while any enabled external pin, after synchronization, is at its active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| tm_sec | input | FIELD_W | Live seconds, BCD |
| tm_min | input | FIELD_W | Live minutes, BCD |
| tm_hour | input | FIELD_W | Live hours, BCD |
| tm_day | input | FIELD_W | Live day of month, BCD |
| tm_mon | input | FIELD_W | Live month, BCD |
| tm_year | input | FIELD_W | Live year, BCD |
| tm_tick | input | 1 | High for one cycle when the seconds value changes |
| ext_wake | input | NUM_PINS | Asynchronous external wakeup pins |
| alarm_irq | output | 1 | Alarm interrupt |
| wake_out | output | 1 | Wake request |
| pwr_en_out | output | 1 | System power enable |

## Verification
Randomly chosen alarm settings are paired with three kinds of live time: exactly equal, equal except for one randomly chosen field, and equal but with the tick low. These patterns tell a full-match comparator apart from one that ignores a field or the tick. Random per-iteration interrupt enables separate the gating of the interrupt from the flag itself. Directed cases cover a clear that coincides with a match, wrong-bit clears, and a second-alarm match with the power function on and with it off. Further directed cases drive wakeup pins that are disabled, at the inactive level, or active in each polarity, which separates the polarity and enable handling from a plain OR of the pins.

// File: rtl/dual_alarm_pkg.sv
package dual_alarm_pkg;

    localparam int NUM_FIELDS   = 6;
    localparam int NUM_ALARMS   = 2;
    localparam int FIELD_STRIDE = 4;

    localparam logic [7:0] OFS_ALM_A = 8'h20;
    localparam logic [7:0] OFS_ALM_B = 8'h80;
    localparam logic [7:0] OFS_STAT  = 8'h44;
    localparam logic [7:0] OFS_IEN   = 8'h48;
    localparam logic [7:0] OFS_WKEN  = 8'h7C;
    localparam logic [7:0] OFS_PWR   = 8'h98;

    localparam int IEN_LSB      = 3;
    localparam int STAT_LSB     = 6;
    localparam int WKEN_BIT     = 1;
    localparam int PWR_FUNC_BIT = 16;

    typedef enum logic {
        PWR_RUN  = 1'b0,
        PWR_DOWN = 1'b1
    } pwr_state_e;

    function automatic logic [7:0] alarm_ofs(input int k, input int f);
        logic [7:0] base;
        base = (k == 0) ? OFS_ALM_A : OFS_ALM_B;
        return base + 8'(FIELD_STRIDE * f);
    endfunction

endpackage

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
    parameter int NUM_FIELDS = 6,
    parameter int FIELD_W    = 8
) (
    input  logic [NUM_FIELDS*FIELD_W-1:0] alarm_i,
    input  logic [NUM_FIELDS*FIELD_W-1:0] live_i,
    input  logic                          tick_i,
    output logic                          match_o
);

    logic [NUM_FIELDS-1:0] field_eq;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        assign field_eq[f] = (alarm_i[f*FIELD_W +: FIELD_W] == live_i[f*FIELD_W +: FIELD_W]);
    end

    assign match_o = tick_i & (&field_eq);

endmodule

// File: rtl/ext_wake_sync.sv
module ext_wake_sync #(
    parameter int NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_PINS-1:0] en_i,
    input  logic [NUM_PINS-1:0] pol_i,
    output logic                hit_o
);

    logic [NUM_PINS-1:0] stage1;
    logic [NUM_PINS-1:0] stage2;
    logic [NUM_PINS-1:0] active;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[p] <= 1'b0;
                stage2[p] <= 1'b0;
            end else begin
                stage1[p] <= pin_i[p];
                stage2[p] <= stage1[p];
            end
        end
        assign active[p] = en_i[p] & (stage2[p] ^ pol_i[p]);
    end

    assign hit_o = |active;

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import dual_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic func_en_i,
    input  logic alarm_b_match_i,
    input  logic ext_hit_i,
    output logic pwr_en_o
);

    pwr_state_e state_q;
    pwr_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PWR_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_RUN: begin
                if (alarm_b_match_i && func_en_i) begin
                    state_d = PWR_DOWN;
                end
            end
            PWR_DOWN: begin
                if (ext_hit_i) begin
                    state_d = PWR_RUN;
                end
            end
            default: state_d = PWR_RUN;
        endcase
    end

    always_comb begin
        pwr_en_o = (state_q == PWR_RUN);
    end

endmodule

// File: rtl/dual_alarm_pwr.sv
module dual_alarm_pwr
    import dual_alarm_pkg::*;
#(
    parameter int FIELD_W  = 8,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [FIELD_W-1:0]  tm_sec,
    input  logic [FIELD_W-1:0]  tm_min,
    input  logic [FIELD_W-1:0]  tm_hour,
    input  logic [FIELD_W-1:0]  tm_day,
    input  logic [FIELD_W-1:0]  tm_mon,
    input  logic [FIELD_W-1:0]  tm_year,
    input  logic                tm_tick,
    input  logic [NUM_PINS-1:0] ext_wake,
    output logic                alarm_irq,
    output logic                wake_out,
    output logic                pwr_en_out
);

    localparam int VEC_W   = NUM_FIELDS * FIELD_W;
    localparam int POL_LSB = NUM_PINS;

    logic [FIELD_W-1:0]    alm_q [NUM_ALARMS][NUM_FIELDS];
    logic [VEC_W-1:0]      alm_flat [NUM_ALARMS];
    logic [VEC_W-1:0]      live_flat;
    logic [NUM_ALARMS-1:0] match;
    logic [NUM_ALARMS-1:0] stat_q;
    logic [NUM_ALARMS-1:0] stat_clr;
    logic [NUM_ALARMS-1:0] ien_q;
    logic                  wken_q;
    logic                  pwr_func_q;
    logic [NUM_PINS-1:0]   pin_en_q;
    logic [NUM_PINS-1:0]   pin_pol_q;
    logic                  ext_hit;
    logic                  wdata_unused;

    assign wdata_unused = ^reg_wdata;

    function automatic logic hit_addr(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    assign live_flat = {tm_year, tm_mon, tm_day, tm_hour, tm_min, tm_sec};

    // alarm field storage and comparators, one per alarm
    for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_alarm
        for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    alm_q[k][f] <= '0;
                end else if (reg_we && hit_addr(reg_addr, alarm_ofs(k, f))) begin
                    alm_q[k][f] <= reg_wdata[FIELD_W-1:0];
                end
            end
            assign alm_flat[k][f*FIELD_W +: FIELD_W] = alm_q[k][f];
        end

        alarm_cmp #(
            .NUM_FIELDS (NUM_FIELDS),
            .FIELD_W    (FIELD_W)
        ) u_cmp (
            .alarm_i (alm_flat[k]),
            .live_i  (live_flat),
            .tick_i  (tm_tick),
            .match_o (match[k])
        );

        // R4: a new match wins over a clear in the same cycle
        assign stat_clr[k] = reg_we && hit_addr(reg_addr, OFS_STAT) && reg_wdata[STAT_LSB + k];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat_q[k] <= 1'b0;
            end else begin
                stat_q[k] <= match[k] | (stat_q[k] & ~stat_clr[k]);
            end
        end
    end

    // control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q      <= '0;
            wken_q     <= 1'b0;
            pwr_func_q <= 1'b0;
            pin_en_q   <= '0;
            pin_pol_q  <= '0;
        end else if (reg_we) begin
            if (hit_addr(reg_addr, OFS_IEN)) begin
                ien_q <= reg_wdata[IEN_LSB +: NUM_ALARMS];
            end
            if (hit_addr(reg_addr, OFS_WKEN)) begin
                wken_q <= reg_wdata[WKEN_BIT];
            end
            if (hit_addr(reg_addr, OFS_PWR)) begin
                pwr_func_q <= reg_wdata[PWR_FUNC_BIT];
                pin_en_q   <= reg_wdata[NUM_PINS-1:0];
                pin_pol_q  <= reg_wdata[POL_LSB +: NUM_PINS];
            end
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NUM_ALARMS; k++) begin
            for (int f = 0; f < NUM_FIELDS; f++) begin
                if (hit_addr(reg_addr, alarm_ofs(k, f))) begin
                    reg_rdata[FIELD_W-1:0] = alm_q[k][f];
                end
            end
        end
        if (hit_addr(reg_addr, OFS_STAT)) begin
            reg_rdata[STAT_LSB +: NUM_ALARMS] = stat_q;
        end
        if (hit_addr(reg_addr, OFS_IEN)) begin
            reg_rdata[IEN_LSB +: NUM_ALARMS] = ien_q;
        end
        if (hit_addr(reg_addr, OFS_WKEN)) begin
            reg_rdata[WKEN_BIT] = wken_q;
        end
        if (hit_addr(reg_addr, OFS_PWR)) begin
            reg_rdata[PWR_FUNC_BIT]          = pwr_func_q;
            reg_rdata[NUM_PINS-1:0]          = pin_en_q;
            reg_rdata[POL_LSB +: NUM_PINS]   = pin_pol_q;
        end
    end

    ext_wake_sync #(
        .NUM_PINS (NUM_PINS)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (ext_wake),
        .en_i  (pin_en_q),
        .pol_i (pin_pol_q),
        .hit_o (ext_hit)
    );

    pwr_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .func_en_i       (pwr_func_q),
        .alarm_b_match_i (match[1]),
        .ext_hit_i       (ext_hit),
        .pwr_en_o        (pwr_en_out)
    );

    assign alarm_irq = |(stat_q & ien_q);
    assign wake_out  = (stat_q[0] & wken_q) | ext_hit;

endmodule

// File: rtl/dual_alarm_pwr_chk.sv
module dual_alarm_pwr_chk
    import dual_alarm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              match_a,
    input logic              match_b,
    input logic              flag_a,
    input logic              flag_b,
    input logic [1:0]        ien,
    input logic              pwr_func,
    input logic              ext_hit,
    input logic              alarm_irq,
    input logic              pwr_en_out
);

    // R3: a flag only rises after its comparator reported a match
    a_r3_flag_a_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_a) |-> $past(match_a));
    a_r3_flag_b_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_b) |-> $past(match_b));

    // R4: a flag only falls after a write-one clear of its bit
    a_r4_flag_a_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_a) |-> ($past(reg_we) && $past(reg_addr) == ADDR_W'(OFS_STAT) && $past(reg_wdata[STAT_LSB])));
    a_r4_flag_b_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_b) |-> ($past(reg_we) && $past(reg_addr) == ADDR_W'(OFS_STAT) && $past(reg_wdata[STAT_LSB+1])));

    // R5: no interrupt without an enable bit
    a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> (ien != 2'b00));

    // R8: power drops only on a second-alarm match with the function on
    a_r8_down_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en_out) |-> ($past(match_b) && $past(pwr_func)));

    // R9: power returns only on an active enabled pin
    a_r9_up_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en_out) |-> $past(ext_hit));

endmodule

bind dual_alarm_pwr dual_alarm_pwr_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .match_a    (match[0]),
    .match_b    (match[1]),
    .flag_a     (stat_q[0]),
    .flag_b     (stat_q[1]),
    .ien        (ien_q),
    .pwr_func   (pwr_func_q),
    .ext_hit    (ext_hit),
    .alarm_irq  (alarm_irq),
    .pwr_en_out (pwr_en_out)
);

// File: tb/dual_alarm_pwr_tb.sv
module dual_alarm_pwr_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  tm_sec = '0, tm_min = '0, tm_hour = '0, tm_day = '0, tm_mon = '0, tm_year = '0;
    logic        tm_tick = 1'b0;
    logic [3:0]  ext_wake = '0;
    logic        alarm_irq, wake_out, pwr_en_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dual_alarm_pwr u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour),
        .tm_day(tm_day), .tm_mon(tm_mon), .tm_year(tm_year), .tm_tick(tm_tick),
        .ext_wake(ext_wake), .alarm_irq(alarm_irq), .wake_out(wake_out),
        .pwr_en_out(pwr_en_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [7:0] fld_ofs(input int k, input int f);
        return ((k == 0) ? 8'h20 : 8'h80) + 8'(4 * f);
    endfunction

    task automatic wr_alarm(input int k, input logic [47:0] v);
        for (int f = 0; f < 6; f++) wr(fld_ofs(k, f), {24'h0, v[8*f +: 8]});
    endtask

    task automatic set_live(input logic [47:0] v);
        {tm_year, tm_mon, tm_day, tm_hour, tm_min, tm_sec} = v;
    endtask

    task automatic pulse(input logic t);
        @(negedge clk); tm_tick = t;
        @(negedge clk); tm_tick = 1'b0;
    endtask

    function automatic logic exp_flag(input logic t, input logic [47:0] a, input logic [47:0] l);
        return t && (a == l);
    endfunction

    function automatic logic exp_irq(input logic [1:0] fl, input logic [1:0] en);
        return |(fl & en);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    localparam logic [47:0] AL_A = 48'h25_12_31_23_59_58;
    localparam logic [47:0] AL_B = 48'h26_01_01_00_00_00;

    initial begin
        logic [31:0] d;
        logic [47:0] av, lv;
        void'($urandom(32'd11));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {31'b0, alarm_irq}, 0);
        chk("R1 wake", {31'b0, wake_out}, 0);
        chk("R1 pwr_en", {31'b0, pwr_en_out}, 1);
        rd(8'h44, d); chk("R1 status", d, 0);
        rd(8'h48, d); chk("R1 ien", d, 0);
        rd(8'h98, d); chk("R1 pwr reg", d, 0);
        rd(8'h2C, d); chk("R1 alarm field", d, 0);

        // R2 alarm field readback
        wr_alarm(0, AL_A);
        wr_alarm(1, AL_B);
        for (int f = 0; f < 6; f++) begin
            rd(fld_ofs(0, f), d); chk("R2 alarm A field", d, {24'h0, AL_A[8*f +: 8]});
            rd(fld_ofs(1, f), d); chk("R2 alarm B field", d, {24'h0, AL_B[8*f +: 8]});
        end

        // R3 year differs, no tick, then full match
        set_live(AL_A ^ 48'h01_00_00_00_00_00);
        pulse(1'b1);
        rd(8'h44, d); chk("R3 one field differs", d, 0);
        set_live(AL_A);
        pulse(1'b0);
        rd(8'h44, d); chk("R3 no tick", d, 0);
        pulse(1'b1);
        rd(8'h44, d); chk("R3 match sets bit6", d, 32'h40);

        // R5 irq gating
        chk("R5 irq off when disabled", {31'b0, alarm_irq}, 0);
        wr(8'h48, 32'h08);
        chk("R5 irq on bit3", {31'b0, alarm_irq}, 1);

        // R6 wake follows flag A
        chk("R6 wake off while disabled", {31'b0, wake_out}, 0);
        wr(8'h7C, 32'h02);
        chk("R6 wake on", {31'b0, wake_out}, 1);

        // R4 clears
        wr(8'h44, 32'h80);
        rd(8'h44, d); chk("R4 wrong bit keeps flag", d, 32'h40);
        wr(8'h44, 32'h40);
        rd(8'h44, d); chk("R4 clear", d, 0);
        chk("R5 irq drops after clear", {31'b0, alarm_irq}, 0);
        chk("R6 wake drops after clear", {31'b0, wake_out}, 0);
        @(negedge clk);
        tm_tick = 1'b1; reg_we = 1'b1; reg_addr = 8'h44; reg_wdata = 32'h40;
        @(negedge clk);
        tm_tick = 1'b0; reg_we = 1'b0; reg_wdata = '0;
        rd(8'h44, d); chk("R4 set beats clear", d, 32'h40);
        wr(8'h44, 32'h40);

        // R8 second alarm, power function off
        set_live(AL_B);
        pulse(1'b1);
        rd(8'h44, d); chk("R3 alarm B sets bit7", d, 32'h80);
        chk("R8 stays up with function off", {31'b0, pwr_en_out}, 1);
        wr(8'h44, 32'h80);

        // R7 power register readback, R8 shutdown
        wr(8'h98, 32'h0001_0001);
        rd(8'h98, d); chk("R7 pwr reg readback", d, 32'h0001_0001);
        wr(8'h48, 32'h10);
        pulse(1'b1);
        chk("R8 power down after match", {31'b0, pwr_en_out}, 0);
        chk("R5 irq on bit4", {31'b0, alarm_irq}, 1);
        wr(8'h44, 32'h80);

        // R9 wakeup: disabled pin ignored, then enabled active-high pin
        ext_wake = 4'b0010;
        repeat (6) @(negedge clk);
        chk("R9 disabled pin ignored", {31'b0, pwr_en_out}, 0);
        chk("R10 disabled pin no wake", {31'b0, wake_out}, 0);
        ext_wake = 4'b0011;
        repeat (3) @(negedge clk);
        chk("R9 power up on pin0", {31'b0, pwr_en_out}, 1);
        chk("R10 wake from pin0", {31'b0, wake_out}, 1);
        ext_wake = 4'b0000;

        // R9 active-low pin 2
        ext_wake = 4'b0100;
        wr(8'h98, 32'h0001_0044);
        rd(8'h98, d); chk("R7 polarity readback", d, 32'h0001_0044);
        repeat (3) @(negedge clk);
        pulse(1'b1);
        chk("R8 power down again", {31'b0, pwr_en_out}, 0);
        repeat (5) @(negedge clk);
        chk("R9 inactive low-pin holds down", {31'b0, pwr_en_out}, 0);
        ext_wake = 4'b0000;
        repeat (3) @(negedge clk);
        chk("R9 power up on active-low pin", {31'b0, pwr_en_out}, 1);
        chk("R10 wake on active-low pin", {31'b0, wake_out}, 1);

        wr(8'h98, 32'h0);
        wr(8'h44, 32'hC0);
        wr(8'h7C, 32'h0);
        wr_alarm(1, 48'hAA_AA_AA_AA_AA_AA);

        // R3/R5 random sweep on alarm A
        for (int i = 0; i < 150; i++) begin
            logic t, e, fl;
            int mode;
            for (int f = 0; f < 6; f++) av[8*f +: 8] = 8'($urandom % 8'h60);
            lv = av;
            mode = $urandom % 3;
            t = (mode != 2);
            if (mode == 1) lv[8*($urandom % 6) +: 8] ^= 8'h01;
            e = 1'($urandom % 2);
            wr(8'h48, {28'h0, e, 3'b000});
            wr_alarm(0, av);
            set_live(lv);
            pulse(t);
            fl = exp_flag(t, av, lv);
            rd(8'h44, d); chk("R3 random status", d, {24'h0, 1'b0, fl, 6'b0});
            chk("R5 random irq", {31'b0, alarm_irq}, {31'b0, exp_irq({1'b0, fl}, {1'b0, e})});
            wr(8'h44, 32'h40);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule